// File: doc/BRIEF.md
# CSR Access Instruction Executor

This block carries out the six control-and-status register access instructions of a 32-bit integer core in a single cycle. It accepts an instruction word, the value of the first source register and a valid strobe, and from these it decodes the register address, the operation and the operand. The operand is either the source register value or a 5-bit unsigned immediate. The block then reads the old register value, forms the new one (replace, bit set or bit clear), writes it back at the next clock edge, and returns the old value with a destination write enable.

The read and write strobes are gated for each instruction. A swap whose destination is x0 performs no read. A set or clear whose source field is x0, or whose immediate is zero, performs no write. To make these side effects observable, the block holds a small register set. It has a bank of scratch registers, a tap register whose every read strobe increments an access counter, and the counter itself, which can be read and cannot be written. All strobes and data are brought out on a register-port interface.

Top module: `csr_exec_unit`

## Requirements
- R1: An instruction acts only when the valid input is high, bits 6..0 equal 1110011, and bits 13..12 are nonzero. The funct3 field in bits 14..12 takes these values: 001 register swap, 010 register set, 011 register clear, 101 immediate swap, 110 immediate set, 111 immediate clear. For any other instruction, both strobes and the destination write enable stay low.
- R2: The register address output equals instruction bits 31..20, and the destination index output equals bits 11..7.
- R3: For both swap forms, when the destination index is 0, the read strobe stays low and the tap access counter does not change.
- R4: Both swap forms always raise the write strobe. The register form writes the source value. The immediate form writes bits 19..15 zero-extended, so an immediate of 0 writes all zeros and an immediate of 31 writes 0x0000001F.
- R5: The set and clear forms raise the read strobe even when the destination index is 0.
- R6: The set and clear forms raise the write strobe exactly when bits 19..15 are nonzero. For the register forms this test uses the field and not the source value, so field x0 with a nonzero value does not write, and a nonzero field with value 0 still writes.
- R7: A set form writes old OR operand. A clear form writes old AND NOT operand.
- R8: The destination write enable is high exactly for an acting instruction whose destination index is nonzero. The destination data then equals the old register value.
- R9: A write lands at the clock edge that ends the instruction's cycle. The destination data in that same cycle shows the value from before the write.
- R10: After reset, every scratch register, the tap register and the access counter read as zero.
- R11: The access counter increases by exactly one for each cycle in which the read strobe is high with the tap address. The counter is readable and ignores writes.
- R12: Addresses outside the register set read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction to execute |
| rs1_value | input | XLEN | Value of the first source register |
| csr_addr | output | 12 | Register address taken from the instruction |
| csr_rd_en | output | 1 | Read strobe |
| csr_wr_en | output | 1 | Write strobe |
| csr_wdata | output | XLEN | New register value |
| csr_rdata | output | XLEN | Read data returned by the register set, zero while not reading |
| rd_we | output | 1 | Destination register write enable |
| rd_index | output | 5 | Destination register index |
| rd_data | output | XLEN | Old register value for the destination |

## Verification
The assertions check on every cycle that the strobes are gated correctly: a swap with a zero destination never reads, a set or clear with a zero source field never writes, and nothing fires without a valid instruction. They also check that each scratch write lands on the following edge and that the access counter moves by one exactly on tap reads. Other behaviour appears only through the bench's instruction sequences. This includes the arithmetic of set and clear, zero extension of the immediate, the difference between a zero source field and a zero source value, the rejection of undefined funct3 codes, and the silence of unmapped addresses and of the counter on writes.

// File: rtl/csrx_pkg.sv
package csrx_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned IDX_W  = 5;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_SWAP = 2'b01,
    KIND_SET  = 2'b10,
    KIND_CLR  = 2'b11
  } csr_kind_e;

  typedef struct packed {
    logic              act;
    csr_kind_e         kind;
    logic              use_imm;
    logic [IDX_W-1:0]  src_field;
    logic [IDX_W-1:0]  dst;
    logic [ADDR_W-1:0] addr;
  } csr_cmd_t;
endpackage

// File: rtl/csrx_decode.sv
module csrx_decode
  import csrx_pkg::*;
(
  input  logic        valid,
  input  logic [31:0] word,
  output csr_cmd_t    cmd,
  output logic        rd_en,
  output logic        wr_en,
  output logic        dst_we
);
  logic [2:0] f3;
  logic       opc_ok;

  always_comb begin
    f3             = word[14:12];
    opc_ok         = (word[6:0] == OPC_SYSTEM);
    cmd.act        = valid && opc_ok && (f3[1:0] != 2'b00);
    cmd.kind       = cmd.act ? csr_kind_e'(f3[1:0]) : KIND_NONE;
    cmd.use_imm    = f3[2];
    cmd.src_field  = word[19:15];
    cmd.dst        = word[11:7];
    cmd.addr       = word[31:20];
    rd_en  = cmd.act && ((cmd.kind != KIND_SWAP) || (cmd.dst != '0));
    wr_en  = cmd.act && ((cmd.kind == KIND_SWAP) || (cmd.src_field != '0));
    dst_we = cmd.act && (cmd.dst != '0);
  end
endmodule

// File: rtl/csrx_alu.sv
module csrx_alu
  import csrx_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  csr_kind_e        kind,
  input  logic             use_imm,
  input  logic [IDX_W-1:0] imm,
  input  logic [XLEN-1:0]  src_value,
  input  logic [XLEN-1:0]  old_value,
  output logic [XLEN-1:0]  new_value
);
  logic [XLEN-1:0] operand;

  always_comb begin
    operand = use_imm ? {{(XLEN-IDX_W){1'b0}}, imm} : src_value;
    unique case (kind)
      KIND_SWAP: new_value = operand;
      KIND_SET:  new_value = old_value | operand;
      KIND_CLR:  new_value = old_value & ~operand;
      default:   new_value = old_value;
    endcase
  end
endmodule

// File: rtl/csrx_regset.sv
module csrx_regset
  import csrx_pkg::*;
#(
  parameter int unsigned XLEN         = 32,
  parameter int unsigned NUM_SCRATCH  = 4,
  parameter logic [11:0] SCRATCH_BASE = 12'h7C0,
  parameter logic [11:0] TAP_ADDR     = 12'h7C8,
  parameter logic [11:0] COUNT_ADDR   = 12'h7C9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [XLEN-1:0]   wdata,
  output logic [XLEN-1:0]   rdata
);
  localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

  logic [XLEN-1:0] scratch_q [NUM_SCRATCH];
  logic [XLEN-1:0] tap_q, tap_d, count_q, count_d;
  logic [NUM_SCRATCH-1:0] hit;
  logic tap_hit, count_hit, count_en;

  assign tap_hit   = (addr == TAP_ADDR);
  assign count_hit = (addr == COUNT_ADDR);
  assign count_en  = rd_en && tap_hit;

  for (genvar i = 0; i < NUM_SCRATCH; i++) begin : g_scratch
    logic [XLEN-1:0] d;
    logic            en;
    assign hit[i] = (addr == 12'(SCRATCH_BASE + i));
    assign en     = wr_en && hit[i];
    assign d      = en ? wdata : scratch_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scratch_q[i] <= '0;
      else        scratch_q[i] <= d;
    end

    a_r9_scratch_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 12'(SCRATCH_BASE + i)) |=> scratch_q[i] == $past(wdata));
    a_r12_scratch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == 12'(SCRATCH_BASE + i)) |=> $stable(scratch_q[i]));
  end

  always_comb begin
    tap_d   = (wr_en && tap_hit) ? wdata : tap_q;
    count_d = count_en ? count_q + ONE : count_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q   <= '0;
      count_q <= '0;
    end else begin
      tap_q   <= tap_d;
      count_q <= count_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_SCRATCH; i++)
      if (hit[i]) rdata = scratch_q[i];
    if (tap_hit)   rdata = tap_q;
    if (count_hit) rdata = count_q;
  end

  a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == TAP_ADDR) |=> count_q == $past(count_q) + ONE);
  a_r11_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && addr == TAP_ADDR) |=> $stable(count_q));
endmodule

// File: rtl/csr_exec_unit.sv
module csr_exec_unit
  import csrx_pkg::*;
#(
  parameter int unsigned XLEN         = 32,
  parameter int unsigned NUM_SCRATCH  = 4,
  parameter logic [11:0] SCRATCH_BASE = 12'h7C0,
  parameter logic [11:0] TAP_ADDR     = 12'h7C8,
  parameter logic [11:0] COUNT_ADDR   = 12'h7C9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [31:0]     instr_word,
  input  logic [XLEN-1:0] rs1_value,
  output logic [11:0]     csr_addr,
  output logic            csr_rd_en,
  output logic            csr_wr_en,
  output logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            rd_we,
  output logic [4:0]      rd_index,
  output logic [XLEN-1:0] rd_data
);
  logic [1:0]      rst_sync_q;
  logic            rst_core_n;
  csr_cmd_t        cmd;
  logic [XLEN-1:0] raw_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  csrx_decode u_decode (
    .valid  (instr_valid),
    .word   (instr_word),
    .cmd    (cmd),
    .rd_en  (csr_rd_en),
    .wr_en  (csr_wr_en),
    .dst_we (rd_we)
  );

  csrx_regset #(
    .XLEN(XLEN), .NUM_SCRATCH(NUM_SCRATCH), .SCRATCH_BASE(SCRATCH_BASE),
    .TAP_ADDR(TAP_ADDR), .COUNT_ADDR(COUNT_ADDR)
  ) u_regset (
    .clk   (clk),
    .rst_n (rst_core_n),
    .addr  (cmd.addr),
    .rd_en (csr_rd_en),
    .wr_en (csr_wr_en),
    .wdata (csr_wdata),
    .rdata (raw_rdata)
  );

  csrx_alu #(.XLEN(XLEN)) u_alu (
    .kind      (cmd.kind),
    .use_imm   (cmd.use_imm),
    .imm       (cmd.src_field),
    .src_value (rs1_value),
    .old_value (raw_rdata),
    .new_value (csr_wdata)
  );

  assign csr_addr  = cmd.addr;
  assign rd_index  = cmd.dst;
  assign csr_rdata = csr_rd_en ? raw_rdata : '0;
  assign rd_data   = csr_rdata;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_core_n)
    !instr_valid |-> !csr_rd_en && !csr_wr_en && !rd_we);
  a_r3_swap_x0_no_read: assert property (@(posedge clk) disable iff (!rst_core_n)
    (instr_valid && instr_word[13:12] == 2'b01 && instr_word[11:7] == 5'd0) |-> !csr_rd_en);
  a_r6_zero_src_no_write: assert property (@(posedge clk) disable iff (!rst_core_n)
    (instr_valid && instr_word[13] && instr_word[19:15] == 5'd0) |-> !csr_wr_en);
  a_r8_dst_nonzero: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_we |-> (rd_index != 5'd0) && instr_valid);
endmodule

// File: tb/csr_exec_unit_bench.sv
`timescale 1ns/1ps
module csr_exec_unit_bench;
  localparam logic [11:0] S0 = 12'h7C0, S1 = 12'h7C1, S2 = 12'h7C2, S3 = 12'h7C3;
  localparam logic [11:0] TAP = 12'h7C8, CNT = 12'h7C9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [31:0] rs1_value = '0;
  logic [11:0] csr_addr;
  logic csr_rd_en, csr_wr_en, rd_we;
  logic [31:0] csr_wdata, csr_rdata, rd_data;
  logic [4:0] rd_index;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_cnt = '0;

  logic        o_rd_en, o_wr_en, o_we;
  logic [31:0] o_data, o_wdata;
  logic [11:0] o_addr;
  logic [4:0]  o_idx;

  always #2.5 clk = ~clk;

  csr_exec_unit u_csr_exec_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .rs1_value(rs1_value), .csr_addr(csr_addr), .csr_rd_en(csr_rd_en),
    .csr_wr_en(csr_wr_en), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .rd_we(rd_we), .rd_index(rd_index), .rd_data(rd_data)
  );

  function automatic logic [31:0] enc(logic [11:0] a, logic [4:0] src, logic [2:0] f3, logic [4:0] rd);
    return {a, src, f3, rd, 7'b1110011};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic exec(logic [31:0] w, logic [31:0] v, logic vld = 1'b1);
    @(negedge clk);
    instr_word = w; rs1_value = v; instr_valid = vld;
    #1;
    o_rd_en = csr_rd_en; o_wr_en = csr_wr_en; o_we = rd_we;
    o_data = rd_data; o_wdata = csr_wdata; o_addr = csr_addr; o_idx = rd_index;
    if (csr_rd_en && csr_addr == TAP) exp_cnt++;
    @(posedge clk); #1;
    instr_valid = 1'b0;
  endtask

  task automatic rd_csr(logic [11:0] a, output logic [31:0] val);
    exec(enc(a, 5'd0, 3'b010, 5'd1), 32'hFFFF_FFFF);
    val = o_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 idle rd strobe", {31'd0, csr_rd_en}, 0);
    check("R1 idle wr strobe", {31'd0, csr_wr_en}, 0);
    rd_csr(S0, v); check("R10 scratch0", v, 0);
    rd_csr(S3, v); check("R10 scratch3", v, 0);
    rd_csr(CNT, v); check("R10 counter", v, 0);
  endtask

  task automatic t_fields;
    exec(enc(S2, 5'd0, 3'b010, 5'd17), 0);
    check("R2 address", {20'd0, o_addr}, {20'd0, S2});
    check("R2 dst index", {27'd0, o_idx}, 17);
  endtask

  task automatic t_swap;
    logic [31:0] v;
    exec(enc(S0, 5'd8, 3'b001, 5'd5), 32'hA5A5_1234);
    check("R8 swap we", {31'd0, o_we}, 1);
    check("R9 swap old data", o_data, 0);
    rd_csr(S0, v); check("R4 swap reg value", v, 32'hA5A5_1234);
    exec(enc(S0, 5'd31, 3'b101, 5'd2), 0);
    check("R9 old before write", o_data, 32'hA5A5_1234);
    rd_csr(S0, v); check("R4 imm 31 zero-extended", v, 32'h0000_001F);
    exec(enc(S1, 5'd3, 3'b001, 5'd0), 32'hFFFF_0000);
    exec(enc(S1, 5'd0, 3'b101, 5'd0), 0);
    check("R3 swap x0 no read", {31'd0, o_rd_en}, 0);
    check("R4 imm 0 still writes", {31'd0, o_wr_en}, 1);
    check("R8 x0 no we", {31'd0, o_we}, 0);
    rd_csr(S1, v); check("R4 imm 0 clears", v, 0);
  endtask

  task automatic t_tap;
    logic [31:0] v;
    exec(enc(TAP, 5'd4, 3'b001, 5'd0), 32'h0000_00C3);
    exec(enc(TAP, 5'd7, 3'b101, 5'd0), 0);
    rd_csr(CNT, v); check("R3 swap x0 counter unchanged", v, exp_cnt);
    check("R3 counter still zero", v, 0);
    exec(enc(TAP, 5'd0, 3'b010, 5'd0), 32'hFFFF_FFFF);
    check("R5 set x0 reads", {31'd0, o_rd_en}, 1);
    exec(enc(TAP, 5'd0, 3'b111, 5'd0), 0);
    check("R5 clear-imm x0 reads", {31'd0, o_rd_en}, 1);
    rd_csr(CNT, v); check("R11 counter after two reads", v, 2);
    exec(enc(TAP, 5'd6, 3'b001, 5'd9), 32'h55);
    check("R11 tap old value", o_data, 32'h7);
    exec(enc(CNT, 5'd5, 3'b101, 5'd0), 0);
    rd_csr(CNT, v); check("R11 counter ignores write", v, 3);
  endtask

  task automatic t_setclear;
    logic [31:0] v;
    exec(enc(S2, 5'd1, 3'b001, 5'd0), 32'hF0F0_0F0F);
    exec(enc(S2, 5'd31, 3'b110, 5'd4), 0);
    check("R7 set-imm old", o_data, 32'hF0F0_0F0F);
    rd_csr(S2, v); check("R7 set-imm result", v, 32'hF0F0_0F1F);
    exec(enc(S2, 5'd7, 3'b011, 5'd4), 32'h0000_0F00);
    rd_csr(S2, v); check("R7 clear reg result", v, 32'hF0F0_001F);
    exec(enc(S2, 5'd3, 3'b111, 5'd4), 0);
    rd_csr(S2, v); check("R7 clear-imm result", v, 32'hF0F0_001C);
    exec(enc(S2, 5'd0, 3'b110, 5'd4), 0);
    check("R6 set-imm 0 no write", {31'd0, o_wr_en}, 0);
  endtask

  task automatic t_src_field;
    logic [31:0] v;
    exec(enc(S3, 5'd2, 3'b001, 5'd0), 32'h0000_0F0F);
    exec(enc(S3, 5'd0, 3'b011, 5'd6), 32'hFFFF_FFFF);
    check("R6 field x0 no write", {31'd0, o_wr_en}, 0);
    rd_csr(S3, v); check("R6 field x0 value kept", v, 32'h0000_0F0F);
    exec(enc(S3, 5'd9, 3'b010, 5'd6), 0);
    check("R6 zero value still writes", {31'd0, o_wr_en}, 1);
    check("R6 written value", o_wdata, 32'h0000_0F0F);
  endtask

  task automatic t_reject;
    logic [31:0] v;
    exec(enc(S0, 5'd1, 3'b000, 5'd3), 32'h1111_1111);
    check("R1 funct3 000 no strobes", {30'd0, o_rd_en, o_wr_en}, 0);
    exec(enc(S0, 5'd1, 3'b100, 5'd3), 32'h1111_1111);
    check("R1 funct3 100 no we", {31'd0, o_we}, 0);
    exec({S0, 5'd1, 3'b001, 5'd3, 7'b0110011}, 32'h2222_2222);
    check("R1 wrong opcode no write", {31'd0, o_wr_en}, 0);
    exec(enc(S0, 5'd1, 3'b001, 5'd3), 32'h3333_3333, 1'b0);
    check("R1 invalid no we", {31'd0, o_we}, 0);
    rd_csr(S0, v); check("R1 scratch0 untouched", v, 32'h0000_001F);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    exec(enc(12'h123, 5'd1, 3'b001, 5'd0), 32'hDEAD_BEEF);
    rd_csr(12'h123, v); check("R12 unmapped reads zero", v, 0);
    rd_csr(S0, v); check("R12 mapped unaffected", v, 32'h0000_001F);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_fields();
    t_swap();
    t_tap();
    t_setclear();
    t_src_field();
    t_reject();
    t_unmapped();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule